// File: doc/BRIEF.md
# Falling-Edge Wake and Interrupt Port Controller

This block watches a seven-pin general-purpose input port for high-to-low transitions. It looks only at pins whose direction bit marks them as inputs. Each detected edge latches a sticky per-pin flag, and software clears that flag. The block produces two requests: a wake request for the low-power sequencer, and a port interrupt request for the core.

The two requests have separate gates. Per-pin release enables gate the wake request. A single global enable gates the interrupt. A pin can therefore wake the core without asking for service, and execution then simply continues. In normal running, the pins pass through a two-flop synchronizer before edge detection. In the clock-stopped state, a release-enabled input pin held low drives the wake request directly, so no clock edge is needed.

Software reaches the four registers through one write port with a 2-bit select. Select 0 is the flag register, 1 is release enable, 2 is direction, and 3 is the interrupt enable. The current contents of all four registers are always visible on output ports.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset, flags are 0, release enables are 0, the interrupt enable is 0, direction is all ones (7'h7F, 1 = input), and both wake_o and irq_o are 0.
- R2: A falling edge on pin n sets flag bit n at the third rising clock edge after the low value is first applied, but only if direction bit n is 1 at that edge. A pin with direction bit 0 never sets its flag.
- R3: A flag bit changes from 1 to 0 only when select 0 is written with a 0 in that bit. Writing a 1 leaves the bit as it was.
- R4: If a hardware set and a software clear of the same flag bit fall in the same cycle, the bit ends up set.
- R5: With stop_mode_i low, wake_o is a one-cycle pulse. It appears on the same edge that sets the flag, and only if release-enable bit n was 1 when the edge was detected.
- R6: irq_o is high exactly when the interrupt enable is 1 and at least one flag bit is 1. With the enable at 0, a release-enabled edge raises wake_o and leaves irq_o low.
- R7: While stop_mode_i is high, wake_o is high whenever some pin is low with both its direction bit and its release-enable bit at 1, with no clock edge needed.
- R8: A low-to-high transition on any pin sets no flag and raises no wake pulse.
- R9: A write with wr_en_i high updates, at the next clock edge, the register chosen by wr_sel_i: 1 is release enable (7 bits), 2 is direction (7 bits), and 3 is the interrupt enable (wr_data_i bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 7 | Monitored port pins |
| stop_mode_i | input | 1 | High while the system clock is stopped |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 flag, 1 release, 2 direction, 3 interrupt enable |
| wr_data_i | input | 7 | Write data |
| flag_o | output | 7 | Sticky falling-edge flags |
| rel_en_o | output | 7 | Per-pin release enables |
| dir_o | output | 7 | Per-pin direction, 1 = input |
| irq_en_o | output | 1 | Global port interrupt enable |
| wake_o | output | 1 | Wake request to the low-power sequencer |
| irq_o | output | 1 | Port interrupt request |

## Verification
A hardware flag set and a software clear can land on the same flag bit in the same cycle. The bench provokes this on purpose. It schedules a flag-register write of zeros for the exact edge at which a known falling edge is due to set that bit, and then requires the bit to read as 1. Random traffic mixes flag writes with pin toggles, so set/clear overlaps also arise on other bits. A bench model scores every one of them, and that model derives the expected flag from the three-edge latency and the set-wins rule.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_FLAG  = 2'd0,
    SEL_REL   = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_IRQEN = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wkp_edge_flag.sv
module wkp_edge_flag #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  // only input-mode pins take part
  assign fall_o = prev_q & ~sync_i & dir_i;

  // set has priority over a same-cycle clear
  for (genvar n = 0; n < W; n++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            flag_q[n] <= 1'b0;
      else if (fall_o[n])     flag_q[n] <= 1'b1;
      else if (clr_mask_i[n]) flag_q[n] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wkp_cfg_regs.sv
module wkp_cfg_regs
  import wkp_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     rel_en_o,
  output logic [W-1:0]     dir_o,
  output logic             irq_en_o,
  output logic [W-1:0]     flag_clr_o
);
  logic [W-1:0] rel_q, dir_q;
  logic         irq_en_q;
  reg_sel_e     sel;

  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q    <= '0;
      dir_q    <= '1;
      irq_en_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_REL:   rel_q    <= wr_data_i;
        SEL_DIR:   dir_q    <= wr_data_i;
        SEL_IRQEN: irq_en_q <= wr_data_i[0];
        default:   ;
      endcase
    end
  end

  // zero bits clear, one bits are ignored
  assign flag_clr_o = (wr_en_i && sel == SEL_FLAG) ? ~wr_data_i : '0;
  assign rel_en_o   = rel_q;
  assign dir_o      = dir_q;
  assign irq_en_o   = irq_en_q;
endmodule

// File: rtl/wkp_req_gen.sv
module wkp_req_gen #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] rel_en_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] pin_i,
  input  logic         stop_i,
  input  logic [W-1:0] flag_i,
  input  logic         irq_en_i,
  output logic         wake_o,
  output logic         irq_o
);
  logic wake_q;
  logic stop_wake;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= |(fall_i & rel_en_i);
  end

  // clock is halted in stop: raw pin level releases directly
  assign stop_wake = stop_i & (|(~pin_i & rel_en_i & dir_i));
  assign wake_o    = wake_q | stop_wake;
  assign irq_o     = irq_en_i & (|flag_i);
endmodule

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl
  import wkp_pkg::*;
#(
  parameter int unsigned W         = 7,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     pin_i,
  input  logic             stop_mode_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     flag_o,
  output logic [W-1:0]     rel_en_o,
  output logic [W-1:0]     dir_o,
  output logic             irq_en_o,
  output logic             wake_o,
  output logic             irq_o
);
  logic [W-1:0] pin_sync, fall, flag_clr;

  wkp_sync #(.W(W), .STAGES(SYNC_DEPTH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  wkp_cfg_regs #(.W(W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rel_en_o  (rel_en_o),
    .dir_o     (dir_o),
    .irq_en_o  (irq_en_o),
    .flag_clr_o(flag_clr)
  );

  wkp_edge_flag #(.W(W)) i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (pin_sync),
    .dir_i     (dir_o),
    .clr_mask_i(flag_clr),
    .fall_o    (fall),
    .flag_o    (flag_o)
  );

  wkp_req_gen #(.W(W)) i_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall),
    .rel_en_i(rel_en_o),
    .dir_i   (dir_o),
    .pin_i   (pin_i),
    .stop_i  (stop_mode_i),
    .flag_i  (flag_o),
    .irq_en_i(irq_en_o),
    .wake_o  (wake_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/edge_wake_ctrl_chk.sv
module edge_wake_ctrl_chk #(
  parameter int unsigned W = 7
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] pin_i,
  input logic         stop_mode_i,
  input logic         wr_en_i,
  input logic [1:0]   wr_sel_i,
  input logic [W-1:0] flag_o,
  input logic [W-1:0] rel_en_o,
  input logic [W-1:0] dir_o,
  input logic         irq_en_o,
  input logic         wake_o,
  input logic         irq_o
);
  p_flag_new_input_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((flag_o & ~$past(flag_o) & ~$past(dir_o)) == '0));

  p_flag_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == 2'd0) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

  p_wake_needs_rel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !stop_mode_i) |-> ($past(rel_en_o) != '0));

  p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_o |-> !irq_o);

  p_stop_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_mode_i && (|(~pin_i & rel_en_o & dir_o))) |-> wake_o);
endmodule

bind edge_wake_ctrl edge_wake_ctrl_chk #(.W(W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pin_i      (pin_i),
  .stop_mode_i(stop_mode_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .flag_o     (flag_o),
  .rel_en_o   (rel_en_o),
  .dir_o      (dir_o),
  .irq_en_o   (irq_en_o),
  .wake_o     (wake_o),
  .irq_o      (irq_o)
);

// File: tb/test_edge_wake_ctrl.sv
`timescale 1ns/1ps
module test_edge_wake_ctrl;
  localparam int W = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin = '0;
  logic         stop = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] flag, rel_en, dir;
  logic         irq_en, wake, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic [W-1:0] m_flag, m_rel, m_dir;
  logic         m_irq;
  logic [W-1:0] pa, pb, pc;

  always #2.5 clk = ~clk;

  edge_wake_ctrl i_edge_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .stop_mode_i(stop),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .flag_o(flag), .rel_en_o(rel_en), .dir_o(dir), .irq_en_o(irq_en),
    .wake_o(wake), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] fall_exp(input logic [W-1:0] older, input logic [W-1:0] newer,
                                            input logic [W-1:0] d);
    return older & ~newer & d;
  endfunction

  task automatic step(input logic [W-1:0] p, input logic we, input logic [1:0] sel,
                      input logic [W-1:0] d, input logic stp);
    logic [W-1:0] f, clr;
    logic         wq, ew;
    @(negedge clk);
    pin = p; wr_en = we; wr_sel = sel; wr_data = d; stop = stp;
    f   = fall_exp(pc, pb, m_dir);
    clr = (we && sel == 2'd0) ? ~d : '0;
    wq  = |(f & m_rel);
    m_flag = (m_flag & ~clr) | f;
    if (we) begin
      case (sel)
        2'd1: m_rel = d;
        2'd2: m_dir = d;
        2'd3: m_irq = d[0];
        default: ;
      endcase
    end
    pc = pb; pb = pa; pa = p;
    @(posedge clk); #1;
    ew = wq | (stp & (|(~p & m_rel & m_dir)));
    chk("R2 flag", 32'(flag), 32'(m_flag));
    chk("R5 wake", 32'(wake), 32'(ew));
    chk("R6 irq", 32'(irq), 32'(m_irq & (|m_flag)));
    chk("R9 regs", {m_irq, m_rel, m_dir}, {irq_en, rel_en, dir});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(pin, 1'b0, 2'd0, '0, 1'b0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    m_flag = '0; m_rel = '0; m_dir = '1; m_irq = 1'b0;
    pa = '0; pb = '0; pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 flag", 32'(flag), 0);
    chk("R1 rel", 32'(rel_en), 0);
    chk("R1 dir", 32'(dir), 32'h7F);
    chk("R1 irq_en/wake/irq", {irq_en, wake, irq}, 0);

    // R8 rising edges: no flag, no wake
    step(7'h7F, 1'b1, 2'd1, 7'h7F, 1'b0);
    idle(4);
    chk("R8 no flag on rise", 32'(flag), 0);

    // R2 exact latency on pin0, R5 pulse with release on
    step(7'h7E, 1'b0, 2'd0, '0, 1'b0);
    step(7'h7E, 1'b0, 2'd0, '0, 1'b0);
    chk("R2 not yet at edge 2", 32'(flag[0]), 0);
    step(7'h7E, 1'b0, 2'd0, '0, 1'b0);
    chk("R2 set at edge 3", 32'(flag[0]), 1);
    chk("R6 wake without irq", {wake, irq}, 32'h2);
    step(7'h7E, 1'b0, 2'd0, '0, 1'b0);
    chk("R5 pulse one cycle", 32'(wake), 0);

    // R3 write ones ignored, write zero clears
    step(7'h7E, 1'b1, 2'd0, 7'h7F, 1'b0);
    chk("R3 write one keeps", 32'(flag[0]), 1);
    step(7'h7E, 1'b1, 2'd0, 7'h7E, 1'b0);
    chk("R3 write zero clears", 32'(flag[0]), 0);

    // R2 output-mode pin ignored
    step(7'h7F, 1'b1, 2'd2, 7'h7D, 1'b0);
    idle(3);
    step(7'h7D, 1'b0, 2'd0, '0, 1'b0);
    idle(4);
    chk("R2 output pin no flag", 32'(flag[1]), 0);
    step(7'h7F, 1'b1, 2'd2, 7'h7F, 1'b0);
    idle(4);

    // R4 set and clear on same edge
    step(7'h7B, 1'b0, 2'd0, '0, 1'b0);
    step(7'h7B, 1'b0, 2'd0, '0, 1'b0);
    step(7'h7B, 1'b1, 2'd0, 7'h00, 1'b0);
    chk("R4 set wins", 32'(flag[2]), 1);

    // R6 enable interrupt
    step(7'h7B, 1'b1, 2'd3, 7'h01, 1'b0);
    chk("R6 irq on", 32'(irq), 1);
    step(7'h7F, 1'b1, 2'd0, 7'h00, 1'b0);
    chk("R6 irq off after clear", 32'(irq), 0);
    idle(4);

    // R7 stop mode wake with no clock edge
    @(negedge clk); stop = 1'b1; pin = 7'h6F; #0.5;
    chk("R7 comb wake", 32'(wake), 1);
    pin = 7'h7F; #0.5;
    chk("R7 released pin", 32'(wake), 0);
    m_flag = m_flag; // pin pulse shorter than a clock: histories unchanged
    step(7'h7F, 1'b0, 2'd0, '0, 1'b0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] p;
      logic         we;
      p  = pin;
      if ($urandom_range(0, 3) == 0) p[$urandom_range(0, W-1)] ^= 1'b1;
      we = ($urandom_range(0, 3) == 0);
      step(p, we, 2'($urandom_range(0, 3)), W'($urandom), ($urandom_range(0, 9) == 0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule